// File: doc/BRIEF.md
# Burst Read Bridge from a Fall-Through FIFO

This block is the read side of an AXI4 slave that answers host read bursts by draining a first-word-fall-through FIFO. The host issues a read address request. The block ignores the address and keeps only the burst length. It then streams that many beats on the read data channel. Each beat that is accepted while the FIFO holds data takes the word at the FIFO head and pops it in the same cycle.

The block never stalls the host for lack of data. Whenever the FIFO is empty during a beat, it still raises the valid signal and sends a filler word instead. The filler is the 32-bit value 0x89ABCDEF repeated across the data width. The host software is expected to know how many real words it is waiting for.

A new read request is accepted on the final beat of a burst. A following burst can therefore start with no idle cycle between the two. Only one burst is ever in flight. The read ID and the response code are constant.

Top module: `fifo_read_bridge`

## Requirements
- R1: After a synchronous active-low reset, the block is idle. In idle, `arReady` is 1 and `rValid` is 0, and the stored burst length and the beat count are both 0.
- R2: While idle, `arReady` is 1 and `rValid` is 0. A cycle with `arValid` high makes `rValid` high from the next cycle on.
- R3: On each request handshake, the 8-bit `arLen` is stored. The burst then carries `arLen`+1 beats. `rLast` is 1 on exactly the final beat, so `arLen`=0 gives one beat and `arLen`=255 gives 256 beats.
- R4: From the first beat until the final beat is taken with `rReady`, `rValid` stays 1 on every cycle, whether or not the FIFO is empty.
- R5: On a beat where `fifoEmpty` is 0, `rData` equals `fifoData`. Successive accepted beats return the FIFO words in the order they were queued.
- R6: On a beat where `fifoEmpty` is 1, `rData` is 32'h89ABCDEF repeated to fill `DATA_W` bits, and no FIFO word is consumed.
- R7: `fifoRdEn` is 1 exactly when `fifoEmpty` is 0, `rValid` is 1 and `rReady` is 1. It is never 1 while the FIFO is empty.
- R8: `arReady` is 1 during a burst only on the final beat with `rReady` high. If `arValid` is high in that cycle, the next burst starts in the following cycle with its beat count at 0. Otherwise the block returns to idle.
- R9: `rId` is always 0 and `rResp` is always 2'b00 (OKAY).
- R10: While `rReady` is 0 during a burst, the beat position, `rLast` and the FIFO head do not change, and `fifoRdEn` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| arValid | input | 1 | Read request valid |
| arLen | input | LEN_W | Burst length minus one |
| arReady | output | 1 | Read request accepted |
| rValid | output | 1 | Read beat valid |
| rReady | input | 1 | Host takes the beat |
| rData | output | DATA_W | Beat data, FIFO word or filler |
| rLast | output | 1 | Final beat of the burst |
| rId | output | ID_W | Read ID, constant 0 |
| rResp | output | 2 | Read response, constant OKAY |
| fifoEmpty | input | 1 | FIFO has no word at its head |
| fifoData | input | DATA_W | FIFO head word (fall-through) |
| fifoRdEn | output | 1 | Pop the FIFO head |

## Verification
The bench runs bursts of 1, 4 and 256 beats. The FIFO model holds fewer words than the burst asks for, so each burst has beats with real data followed by filler beats. This separates in-order popping from filler insertion and from any pop while empty. A single-beat burst against an empty FIFO isolates the filler path on its own. A burst with host stalls on a middle beat and on the final beat shows whether the beat count, `rLast` and the pop are held correctly. Two chained bursts, with the second request held from the first beat on, tell apart acceptance on the final beat from early acceptance and from an idle gap between the bursts.

// File: rtl/fifo_read_bridge_pkg.sv
package fifo_read_bridge_pkg;

  // Read-path state: waiting for a request, or streaming a burst
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } rdState_t;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic arHs;  // request handshake this cycle
    logic rHs;   // beat handshake this cycle
  } rdStrobes_t;

endpackage

// File: rtl/fifo_read_bridge_ctrl.sv
module fifo_read_bridge_ctrl
  import fifo_read_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       arValid,
  input  logic       rReady,
  input  logic       lastBeat,
  output logic       arReady,
  output logic       rValid,
  output rdStrobes_t strb
);

  rdState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    arReady   = 1'b0;
    rValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        arReady = 1'b1;
        if (arValid) nextState = ST_DATA;
      end
      ST_DATA: begin
        rValid = 1'b1;
        if (rReady && lastBeat) begin
          arReady = 1'b1;
          if (!arValid) nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign strb.arHs = arReady & arValid;
  assign strb.rHs  = rValid & rReady;

  // R2: with no burst active, a request can always be taken
  p_idle_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rValid |-> arReady);

  // R4: valid is held until the final beat is taken
  p_valid_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !(rReady && lastBeat)) |=> rValid);

  // R8: a request on the final beat chains straight into the next burst
  p_chain_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rReady && lastBeat && arValid) |=> rValid);

  // R8: no request is taken in the middle of a burst
  p_no_early_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !(rReady && lastBeat)) |-> !arReady);

endmodule

// File: rtl/fifo_read_bridge_dp.sv
module fifo_read_bridge_dp
  import fifo_read_bridge_pkg::*;
#(
  parameter int          DATA_W    = 512,
  parameter int          LEN_W     = 8,
  parameter int          FILL_W    = 32,
  parameter logic [31:0] FILL_WORD = 32'h89AB_CDEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobes_t        strb,
  input  logic [LEN_W-1:0]  arLen,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] fifoData,
  output logic [DATA_W-1:0] rData,
  output logic              rLast,
  output logic              fifoRdEn
);

  localparam int FILL_REPS = DATA_W / FILL_W;

  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  beatCnt;
  logic [DATA_W-1:0] fillVec;

  // Filler word replicated across the data width
  for (genvar i = 0; i < FILL_REPS; i++) begin : g_fill
    assign fillVec[i*FILL_W +: FILL_W] = FILL_WORD[FILL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          lenReg <= '0;
    else if (strb.arHs) lenReg <= arLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.arHs) beatCnt <= '0;
    else if (strb.rHs)      beatCnt <= beatCnt + 1'b1;
  end

  assign rLast    = (beatCnt == lenReg);
  assign rData    = fifoEmpty ? fillVec : fifoData;
  assign fifoRdEn = strb.rHs & ~fifoEmpty;

  // R3: the requested length is held for the burst
  p_len_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.arHs |=> (lenReg == $past(arLen)));

  // R8: every new burst starts counting from zero
  p_count_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.arHs |=> (beatCnt == '0));

  // R10: without a handshake the beat position does not move
  p_count_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rHs && !strb.arHs) |=> $stable(beatCnt));

  // R7: never pop an empty FIFO
  p_pop_not_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    fifoRdEn |-> !fifoEmpty);

endmodule

// File: rtl/fifo_read_bridge.sv
module fifo_read_bridge
  import fifo_read_bridge_pkg::*;
#(
  parameter int          DATA_W    = 512,
  parameter int          LEN_W     = 8,
  parameter int          ID_W      = 4,
  parameter int          FILL_W    = 32,
  parameter logic [31:0] FILL_WORD = 32'h89AB_CDEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arValid,
  input  logic [LEN_W-1:0]  arLen,
  output logic              arReady,
  output logic              rValid,
  input  logic              rReady,
  output logic [DATA_W-1:0] rData,
  output logic              rLast,
  output logic [ID_W-1:0]   rId,
  output logic [1:0]        rResp,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] fifoData,
  output logic              fifoRdEn
);

  rdStrobes_t strb;

  fifo_read_bridge_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .arValid  (arValid),
    .rReady   (rReady),
    .lastBeat (rLast),
    .arReady  (arReady),
    .rValid   (rValid),
    .strb     (strb)
  );

  fifo_read_bridge_dp #(
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W),
    .FILL_W    (FILL_W),
    .FILL_WORD (FILL_WORD)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .arLen     (arLen),
    .fifoEmpty (fifoEmpty),
    .fifoData  (fifoData),
    .rData     (rData),
    .rLast     (rLast),
    .fifoRdEn  (fifoRdEn)
  );

  // R9: single ID, always OKAY
  assign rId   = '0;
  assign rResp = 2'b00;

endmodule

// File: tb/fifo_read_bridge_test.sv
module fifo_read_bridge_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 512;
  localparam int REPS       = DATA_W / 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              arValid;
  logic [7:0]        arLen;
  logic              arReady;
  logic              rValid;
  logic              rReady;
  logic [DATA_W-1:0] rData;
  logic              rLast;
  logic [3:0]        rId;
  logic [1:0]        rResp;
  logic              fifoEmpty;
  logic [DATA_W-1:0] fifoData;
  logic              fifoRdEn;

  int checks   = 0;
  int failures = 0;
  int head     = 0;  // FIFO model head, moved by the design's pops
  int loaded   = 0;  // number of words ever queued
  int expHead  = 0;  // bench's own expectation of the head
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_read_bridge uut (
    .clk(clk), .rstN(rstN), .arValid(arValid), .arLen(arLen),
    .arReady(arReady), .rValid(rValid), .rReady(rReady), .rData(rData),
    .rLast(rLast), .rId(rId), .rResp(rResp), .fifoEmpty(fifoEmpty),
    .fifoData(fifoData), .fifoRdEn(fifoRdEn)
  );

  function automatic logic [DATA_W-1:0] wordOf(input int idx);
    logic [31:0] w = 32'h3C00_0000 ^ 32'(idx);
    return {REPS{w}};
  endfunction

  localparam logic [DATA_W-1:0] FILLER = {REPS{32'h89AB_CDEF}};

  // Fall-through FIFO model
  assign fifoEmpty = (head >= loaded);
  assign fifoData  = wordOf(head);
  always @(posedge clk) if (rstN && fifoRdEn) head <= head + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  endtask

  // One beat taken by the host; checks everything visible on it
  task automatic takeBeat(input bit isLast, input string req);
    bit emp = (expHead >= loaded);
    logic [DATA_W-1:0] expData = emp ? FILLER : wordOf(expHead);
    rReady = 1'b1;
    #1;
    chk(rValid == 1'b1, "R4", "rValid on beat", 64'(rValid), 64'd1);
    chk(rLast == isLast, "R3", "rLast placement", 64'(rLast), 64'(isLast));
    chk(rData == expData, emp ? "R6" : "R5", "rData", rData[63:0], expData[63:0]);
    chk(fifoRdEn == !emp, "R7", "fifoRdEn", 64'(fifoRdEn), 64'(!emp));
    chk(arReady == isLast, "R8", "arReady on beat", 64'(arReady), 64'(isLast));
    chk(rId == 4'd0 && rResp == 2'b00, req, "rId/rResp", 64'({rId, rResp}), 64'd0);
    tick();
    if (!emp) expHead++;
  endtask

  // Host holds off for n cycles on the current beat
  task automatic stallBeat(input int n, input bit isLast);
    rReady = 1'b0;
    for (int k = 0; k < n; k++) begin
      #1;
      chk(rValid == 1'b1, "R4", "rValid while stalled", 64'(rValid), 64'd1);
      chk(fifoRdEn == 1'b0, "R10", "no pop while stalled", 64'(fifoRdEn), 64'd0);
      chk(rLast == isLast, "R10", "rLast held", 64'(rLast), 64'(isLast));
      chk(arReady == 1'b0, "R8", "arReady while stalled", 64'(arReady), 64'd0);
      tick();
      chk(head == expHead, "R10", "FIFO head held", 64'(head), 64'(expHead));
    end
  endtask

  task automatic issueReq(input int len);
    arValid = 1'b1;
    arLen   = 8'(len);
    #1;
    chk(arReady == 1'b1 && rValid == 1'b0, "R2", "idle before request",
        64'({arReady, rValid}), 64'b10);
    tick();
    arValid = 1'b0;
  endtask

  task automatic expectIdle(input string what);
    #1;
    chk(rValid == 1'b0 && arReady == 1'b1, "R2", what, 64'({arReady, rValid}), 64'b10);
  endtask

  task automatic runBurst(input int len, input int avail,
                          input int stallAt, input int stallLen, input string req);
    loaded = head + avail;
    expHead = head;
    issueReq(len);
    for (int b = 0; b <= len; b++) begin
      if (b == stallAt) stallBeat(stallLen, b == len);
      takeBeat(b == len, req);
    end
    rReady = 1'b0;
    expectIdle("idle after burst");
    chk(head == expHead, "R7", "words consumed", 64'(head), 64'(expHead));
  endtask

  task automatic testReset();
    #1;
    chk(arReady == 1'b1, "R1", "arReady after reset", 64'(arReady), 64'd1);
    chk(rValid == 1'b0, "R1", "rValid after reset", 64'(rValid), 64'd0);
    chk(rId == 4'd0 && rResp == 2'b00, "R9", "rId/rResp after reset", 64'({rId, rResp}), 64'd0);
  endtask

  // Second request held from the first beat; accepted only on the final one
  task automatic testChain();
    loaded  = head + 10;
    expHead = head;
    issueReq(1);
    arValid = 1'b1;
    arLen   = 8'd2;
    takeBeat(1'b0, "R8");
    takeBeat(1'b1, "R8");
    arValid = 1'b0;
    for (int b = 0; b <= 2; b++) takeBeat(b == 2, "R8");
    rReady = 1'b0;
    expectIdle("idle after chained bursts");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rstN = 1'b0; arValid = 1'b0; arLen = '0; rReady = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    testReset();                    // R1, R9
    runBurst(0, 1, -1, 0, "R3");    // single beat with data
    runBurst(0, 0, -1, 0, "R6");    // single beat, FIFO empty
    runBurst(3, 2, -1, 0, "R5");    // 4 beats, runs empty after 2
    runBurst(3, 4, 1, 3, "R10");    // stall on a middle beat
    runBurst(3, 4, 3, 2, "R10");    // stall on the final beat
    runBurst(255, 100, -1, 0, "R3");// 256 beats, runs empty after 100
    testChain();                    // R8
    summary();
  end

endmodule